// File: doc/BRIEF.md
# Receive Byte FIFO with Status

This block buffers received bytes between a network-side byte source and a host data register. The network side pushes one byte per cycle with `net_push`. The host pops the oldest byte with `host_rd`, and the popped byte appears on `rd_data` one cycle later. For diagnostics, the host can also write a byte through `host_wr`. That byte enters at the network end of the queue, exactly like a received byte.

The FIFO holds 15 bytes. It reports its live occupancy on a 4-bit count, with registered empty and full flags beside it. It also has a sticky overrun flag that records any push attempted while the FIFO was full. `fifo_clr` empties the queue and clears the overrun flag. `core_rst` and `rst_n` do the same, and they also clear the busy flag.

The busy flag comes from a two-state machine with states BUSY_IDLE and BUSY_RUN. There are three transitions:
- The IDLE_TO_RUN transition fires when `rx_start` is seen in BUSY_IDLE.
- The RUN_TO_IDLE transition fires when `rx_reset` is seen in BUSY_RUN.
- The FORCE_IDLE transition fires from either state on `core_rst` or `rst_n` low. It also fires when `rx_reset` is seen in the same cycle as `rx_start`.

Top module: `rxbyte_fifo`

## Requirements
- R1: After `rst_n` is low, the outputs are as follows: `fill_cnt`=0, `fifo_empty`=1, `fifo_full`=0, `overrun`=0, `busy`=0 and `rd_data`=0x00.
- R2: Bytes leave in the order they entered. Up to 15 bytes are held. `fill_cnt` is 4 bits wide and reads 15 with `fifo_full`=1 when the FIFO holds 15 bytes.
- R3: A `host_rd` on a non-empty FIFO removes the oldest byte. That byte appears on `rd_data` in the cycle after the read and holds there until the next read.
- R4: A push (network or diagnostic) while `fifo_full`=1 is discarded. The stored bytes and the count stay unchanged, and `overrun` goes to 1 in the next cycle.
- R5: `overrun` stays 1 through any pushes and pops until `fifo_clr`, `core_rst` or `rst_n` clears it.
- R6: A `host_rd` while `fifo_empty`=1 sets `rd_data` to 0x00 and leaves the count and the read position unchanged.
- R7: A push and a pop in the same cycle on a non-empty FIFO leave the count unchanged. On an empty FIFO, the pop is ignored and the count rises by one.
- R8: A `host_wr` pushes `host_wdata` at the network end. If `net_push` is high in the same cycle, the network byte is stored and the host byte is dropped.
- R9: `fill_cnt`, `fifo_empty` and `fifo_full` are registered. They change only at the clock edge that completes an operation.
- R10: Busy state machine: IDLE_TO_RUN on `rx_start` sets `busy`=1, and RUN_TO_IDLE on `rx_reset` clears it. When both are high in one cycle, `rx_reset` wins.
- R11: `fifo_clr` empties the FIFO and clears `overrun` in the next cycle. It leaves `busy` unchanged.
- R12: `core_rst` empties the FIFO and clears `overrun` and `busy` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous global reset |
| core_rst | input | 1 | Synchronous core reset: clears the queue, overrun and busy |
| fifo_clr | input | 1 | Synchronous queue clear: clears contents and overrun |
| rx_start | input | 1 | Receive-start control strobe |
| rx_reset | input | 1 | Receive-reset control strobe |
| net_push | input | 1 | Network-side push strobe |
| net_data | input | 8 | Network-side byte |
| host_wr | input | 1 | Diagnostic host write strobe |
| host_wdata | input | 8 | Diagnostic host write byte |
| host_rd | input | 1 | Host read (pop) strobe |
| rd_data | output | 8 | Byte returned by the last host read |
| fill_cnt | output | 4 | Occupancy, 0 to 15 |
| fifo_empty | output | 1 | Occupancy is zero |
| fifo_full | output | 1 | Occupancy is 15 |
| overrun | output | 1 | Sticky push-while-full flag |
| busy | output | 1 | Receive busy flag |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and a depth of 15. With that depth, the pointers wrap at index 14 rather than at a power of two, and the 4-bit count reaches its top value of 15 without folding to zero. Both the full condition and the wrap are reached within sixteen pushes. A drain that follows the fill crosses the pointer wrap, so ordering across the wrap is checked against the bytes that were pushed.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic {
        BUSY_IDLE = 1'b0,
        BUSY_RUN  = 1'b1
    } rxf_busy_e;
endpackage

// File: rtl/rxf_busy_fsm.sv
module rxf_busy_fsm
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_rst,
    input  logic rx_start,
    input  logic rx_reset,
    output logic busy
);
    rxf_busy_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUSY_IDLE: if (rx_start && !rx_reset) state_d = BUSY_RUN;   // IDLE_TO_RUN
            BUSY_RUN:  if (rx_reset)              state_d = BUSY_IDLE;  // RUN_TO_IDLE
            default:                              state_d = BUSY_IDLE;
        endcase
        if (core_rst) state_d = BUSY_IDLE;                              // FORCE_IDLE
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUSY_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy = (state_q == BUSY_RUN);
    end
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 15,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_byte,
    input  logic              pop_req,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill_cnt,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              overrun
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop, drop_push;
    logic [CNT_W-1:0]  cnt_d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push   = push_req && !fifo_full;
        drop_push = push_req && fifo_full;
        do_pop    = pop_req && !fifo_empty;
        unique case ({do_push, do_pop})
            2'b10:   cnt_d = fill_cnt + 1'b1;
            2'b01:   cnt_d = fill_cnt - 1'b1;
            default: cnt_d = fill_cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            fill_cnt   <= '0;
            fifo_empty <= 1'b1;
            fifo_full  <= 1'b0;
            overrun    <= 1'b0;
            rd_data    <= '0;
        end else if (clr) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            fill_cnt   <= '0;
            fifo_empty <= 1'b1;
            fifo_full  <= 1'b0;
            overrun    <= 1'b0;
            rd_data    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop) begin
                rd_ptr  <= bump(rd_ptr);
                rd_data <= mem[rd_ptr];
            end else if (pop_req) begin
                rd_data <= '0;
            end
            if (drop_push) overrun <= 1'b1;
            fill_cnt   <= cnt_d;
            fifo_empty <= (cnt_d == '0);
            fifo_full  <= (cnt_d == FULL_CNT);
        end
    end
endmodule

// File: rtl/rxbyte_fifo.sv
module rxbyte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 15,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_rst,
    input  logic              fifo_clr,
    input  logic              rx_start,
    input  logic              rx_reset,
    input  logic              net_push,
    input  logic [DATA_W-1:0] net_data,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill_cnt,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              overrun,
    output logic              busy
);
    logic              push_req;
    logic [DATA_W-1:0] push_byte;
    logic              q_clr;

    // network byte has priority over the diagnostic write
    always_comb begin
        push_req  = net_push || host_wr;
        push_byte = net_push ? net_data : host_wdata;
        q_clr     = fifo_clr || core_rst;
    end

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (q_clr),
        .push_req   (push_req),
        .push_byte  (push_byte),
        .pop_req    (host_rd),
        .rd_data    (rd_data),
        .fill_cnt   (fill_cnt),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .overrun    (overrun)
    );

    rxf_busy_fsm u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .core_rst (core_rst),
        .rx_start (rx_start),
        .rx_reset (rx_reset),
        .busy     (busy)
    );
endmodule

// File: rtl/rxbyte_fifo_chk.sv
module rxbyte_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 15,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_rst,
    input logic              fifo_clr,
    input logic              rx_start,
    input logic              rx_reset,
    input logic              net_push,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  fill_cnt,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic              overrun,
    input logic              busy
);
    logic any_push, any_clr;
    assign any_push = net_push || host_wr;
    assign any_clr  = fifo_clr || core_rst;

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt <= CNT_W'(DEPTH)) && (fifo_full == (fill_cnt == CNT_W'(DEPTH))));

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && any_push && !host_rd && !any_clr |=> fifo_full && overrun);

    // R5
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !any_clr |=> overrun);

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty && host_rd && !any_push && !any_clr |=> (rd_data == '0) && fifo_empty);

    // R7
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty && !fifo_full && any_push && host_rd && !any_clr |=> $stable(fill_cnt));

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_clr && !any_push && !host_rd |=> $stable(fill_cnt));

    // R10
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start && !rx_reset && !core_rst |=> busy);

    // R10
    busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> !busy);

    // R11
    fifo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> fifo_empty && !overrun);

    // R12
    core_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> fifo_empty && !overrun && !busy);
endmodule

bind rxbyte_fifo rxbyte_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_rxbyte_fifo.sv
module tb_rxbyte_fifo;
    localparam int CLK_HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_rst = 1'b0, fifo_clr = 1'b0, rx_start = 1'b0, rx_reset = 1'b0;
    logic       net_push = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] net_data = '0, host_wdata = '0;
    logic [7:0] rd_data;
    logic [3:0] fill_cnt;
    logic       fifo_empty, fifo_full, overrun, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #CLK_HALF clk = ~clk;

    rxbyte_fifo dut (
        .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .fifo_clr(fifo_clr),
        .rx_start(rx_start), .rx_reset(rx_reset),
        .net_push(net_push), .net_data(net_data),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .rd_data(rd_data), .fill_cnt(fill_cnt), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .overrun(overrun), .busy(busy)
    );

    // vector: {net_push, net_data, host_wr, host_wdata, host_rd, exp_cnt, chk_rd, exp_rd}
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1, 8'hA1, 1'b0, 8'h00, 1'b0, 4'd1, 1'b0, 8'h00},  // R2 push
        {1'b1, 8'hB2, 1'b0, 8'h00, 1'b0, 4'd2, 1'b0, 8'h00},  // R2 push
        {1'b0, 8'h00, 1'b1, 8'hC3, 1'b0, 4'd3, 1'b0, 8'h00},  // R8 diag write
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd2, 1'b1, 8'hA1},  // R3 pop
        {1'b1, 8'hD4, 1'b0, 8'h00, 1'b1, 4'd2, 1'b1, 8'hB2},  // R7 push+pop
        {1'b1, 8'hE5, 1'b1, 8'h99, 1'b0, 4'd3, 1'b0, 8'h00},  // R8 net wins
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd2, 1'b1, 8'hC3},  // R3
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd1, 1'b1, 8'hD4},  // R3
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd0, 1'b1, 8'hE5},  // R8 0x99 dropped
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd0, 1'b1, 8'h00},  // R6 empty pop
        {1'b1, 8'h66, 1'b0, 8'h00, 1'b1, 4'd1, 1'b1, 8'h00},  // R7 empty: pop ignored
        {1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd0, 1'b1, 8'h66}   // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive for one cycle from a falling edge; return at the next falling edge
    task automatic cyc(input logic np, input logic [7:0] nd, input logic hw,
                       input logic [7:0] hd, input logic rd);
        net_push = np; net_data = nd; host_wr = hw; host_wdata = hd; host_rd = rd;
        @(negedge clk);
        net_push = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic ctl(input logic st, input logic rs, input logic fc, input logic cr);
        rx_start = st; rx_reset = rs; fifo_clr = fc; core_rst = cr;
        @(negedge clk);
        rx_start = 1'b0; rx_reset = 1'b0; fifo_clr = 1'b0; core_rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cnt", 32'(fill_cnt), 0);
        chk("R1 empty/full/ovr/busy", {fifo_empty, fifo_full, overrun, busy}, 4'b1000);
        chk("R1 rd_data", 32'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            cyc(v[31], v[30:23], v[22], v[21:14], v[13]);
            chk("R2/R3/R6/R7/R8 cnt", 32'(fill_cnt), 32'(v[12:9]));
            if (v[8]) chk("R3/R6/R8 rd_data", 32'(rd_data), 32'(v[7:0]));
        end

        // R9: count holds until the clock edge
        net_push = 1'b1; net_data = 8'h10;
        #1 chk("R9 cnt before edge", 32'(fill_cnt), 0);
        chk("R9 empty before edge", 32'(fifo_empty), 1);
        @(negedge clk);
        net_push = 1'b0;
        chk("R9 cnt after edge", 32'(fill_cnt), 1);
        chk("R9 empty after edge", 32'(fifo_empty), 0);

        // R2 fill to 15
        for (int i = 1; i < 15; i++) begin
            cyc(1'b1, 8'(8'h10 + i), 1'b0, 8'h00, 1'b0);
            if (i == 13) chk("R2 not full at 14", 32'(fifo_full), 0);
        end
        chk("R2 full count", 32'(fill_cnt), 15);
        chk("R2 full flag", 32'(fifo_full), 1);
        chk("R4 no overrun yet", 32'(overrun), 0);

        // R4 push while full
        cyc(1'b1, 8'hEE, 1'b0, 8'h00, 1'b0);
        chk("R4 count held", 32'(fill_cnt), 15);
        chk("R4 overrun set", 32'(overrun), 1);
        cyc(1'b0, 8'h00, 1'b1, 8'hEF, 1'b0);
        chk("R4 diag push dropped", 32'(fill_cnt), 15);

        // R3/R4 drain across the wrap: data unchanged by the dropped pushes
        for (int i = 0; i < 15; i++) begin
            cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
            chk("R3/R4 drain order", 32'(rd_data), 32'(8'h10 + i));
        end
        chk("R6 empty after drain", 32'(fifo_empty), 1);
        chk("R5 overrun sticky", 32'(overrun), 1);
        cyc(1'b1, 8'h21, 1'b0, 8'h00, 1'b0);
        cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        chk("R5 overrun after traffic", 32'(overrun), 1);
        chk("R2 wrap order", 32'(rd_data), 32'h21);

        // R10 busy state machine
        ctl(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 start sets busy", 32'(busy), 1);

        // R11 clear keeps busy
        cyc(1'b1, 8'h31, 1'b0, 8'h00, 1'b0);
        ctl(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R11 cleared cnt", 32'(fill_cnt), 0);
        chk("R11 overrun cleared", 32'(overrun), 0);
        chk("R11 busy kept", 32'(busy), 1);
        cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        chk("R11 nothing left", 32'(rd_data), 0);

        ctl(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R10 reset wins", 32'(busy), 0);
        ctl(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 start again", 32'(busy), 1);
        ctl(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10 rx_reset clears", 32'(busy), 0);

        // R12 core reset
        ctl(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) cyc(1'b1, 8'(i), 1'b0, 8'h00, 1'b0);
        chk("R12 pre overrun", 32'(overrun), 1);
        ctl(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R12 cnt", 32'(fill_cnt), 0);
        chk("R12 flags", {fifo_empty, overrun, busy}, 3'b100);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule